// File: doc/BRIEF.md
# Overflow Timer with Register Interface

A 32-bit up-counting timer reached through a simple word-addressed register port: write strobe, byte offset, write data and a combinational read-data return. Software loads a start value into the counter, picks a reload value, sets the run and auto-reload control bits, and is told through an interrupt line when the counter rolls past all-ones.

The interrupt block keeps pending events in a raw view and a masked view. Enables are changed through a pair of write-one-to-set and write-one-to-clear offsets, and pending bits are acknowledged by writing ones. A write to the sync-control offset starts a fixed-length soft reset that returns every piece of state to zero. Software polls a busy flag until the reset has finished.

Top module: `ovf_timer`

## Requirements
- R1: After the active-low reset every readable offset returns zero except ident (0x00), which returns the ID_VALUE parameter (default 0x47540100). Offsets not listed in these requirements read zero, and so does the sync-control offset 0x54.
- R2: While control (0x38) bit 0 (run) is 1, the counter (0x3C) rises by one every clock. While run is 0 it holds its value.
- R3: A write to 0x3C loads the written value on the next edge, overriding the increment of that cycle and cancelling any overflow in that cycle.
- R4: When run is 1, the counter is 0xFFFFFFFF and control bit 1 (auto-reload) is 1, the next edge loads the counter from the load register (0x40) and run stays 1.
- R5: When run is 1, the counter is 0xFFFFFFFF and auto-reload is 0, the next edge sets the counter to zero and clears run. A control write in that same cycle takes precedence over clearing run.
- R6: Each overflow sets raw status (0x24) bit 1 regardless of the enables. Status (0x28) reads raw AND enable. Output irq is high exactly when a status bit is 1.
- R7: Writing ones to 0x2C sets the matching enable bits. Writing ones to 0x30 clears them, and clear wins when both apply. Both offsets read back the 3-bit enable mask.
- R8: Writing ones to 0x28 clears the matching raw bits. An overflow in the same cycle leaves bit 1 set.
- R9: A write to 0x54 with bit 1 set clears control, counter, load, match, enables and raw status on that edge. Config (0x10) bit 0 then reads 1 for SRST_CYCLES cycles (default 4). All register writes are ignored while it reads 1.
- R10: The match register (0x4C) stores and returns any 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for addr, combinational |
| irq | output | 1 | OR of pending enabled events |

## Verification
Directed sequences cover the specific cases. Counting is checked from zero and from a preload. Overflow is checked with auto-reload, which separates reload from wrap. It is also checked as a one-shot, which shows whether run is cleared. Acknowledges and enable changes are made with overflows pending and with the line masked, to tell the raw view apart from the masked view. A soft reset followed by writes inside the busy window shows whether those writes are dropped. A long random phase then mixes all offsets, counter preloads close to all-ones and repeated soft resets. Every cycle is compared with a bench model of the requirements, so collisions such as an acknowledge on the overflow edge get covered.

// File: rtl/ovf_timer_pkg.sv
// Package: shared offsets and interrupt layout for the overflow timer.
// Assumes byte offsets fit in 8 bits; the top zero-extends them to ADDR_W.
package ovf_timer_pkg;
    localparam int IRQ_N = 3;              // match, overflow, capture sources
    localparam int IRQ_OVF_BIT = 1;        // overflow event position
    localparam logic [7:0] OFF_IDENT   = 8'h00;
    localparam logic [7:0] OFF_CONFIG  = 8'h10;
    localparam logic [7:0] OFF_RAW     = 8'h24;
    localparam logic [7:0] OFF_STATUS  = 8'h28;
    localparam logic [7:0] OFF_EN_SET  = 8'h2C;
    localparam logic [7:0] OFF_EN_CLR  = 8'h30;
    localparam logic [7:0] OFF_CTRL    = 8'h38;
    localparam logic [7:0] OFF_COUNT   = 8'h3C;
    localparam logic [7:0] OFF_LOAD    = 8'h40;
    localparam logic [7:0] OFF_MATCH   = 8'h4C;
    localparam logic [7:0] OFF_SYNC    = 8'h54;
endpackage

// File: rtl/ovf_timer_srst.sv
// Module: soft-reset sequencer. A request starts a clear that lasts
// CYCLES clocks; requests arriving while busy are dropped.
// Assumes CYCLES >= 1.
module ovf_timer_srst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic sclr
);
    localparam int BW = $clog2(CYCLES + 1);
    localparam logic [BW-1:0] START_VAL = BW'(CYCLES);

    logic [BW-1:0] left_q;
    logic          start;

    assign busy  = (left_q != '0);
    assign start = req && !busy;
    assign sclr  = start || busy;

    // Load the remaining-cycle count on a request, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (start)  left_q <= START_VAL;
        else if (busy)   left_q <= left_q - 1'b1;
    end

    // R9: an accepted request makes busy visible on the next cycle.
    a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R9: busy never outlasts the programmed window (count only falls).
    a_r9_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (left_q < $past(left_q)));
endmodule

// File: rtl/ovf_timer_count.sv
// Module: counter datapath with control and load registers.
// Counts while run is set; on all-ones either reloads (auto-reload)
// or wraps to zero and stops. sclr zeroes everything and wins over writes.
module ovf_timer_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclr,
    input  logic              cnt_wr,
    input  logic              load_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] load,
    output logic              run,
    output logic              autoreload,
    output logic              ovf_evt
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    assign ovf_evt = run && !cnt_wr && (&count);

    // Counter: write beats increment; overflow reloads or wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr)   count <= '0;
        else if (cnt_wr)      count <= wdata;
        else if (ovf_evt)     count <= autoreload ? load : '0;
        else if (run)         count <= count + ONE;
    end

    // Load register: plain storage used on auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr)   load <= '0;
        else if (load_wr)     load <= wdata;
    end

    // Control bits: written by software, run cleared by a one-shot overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr) begin
            run        <= 1'b0;
            autoreload <= 1'b0;
        end else if (ctrl_wr) begin
            run        <= wdata[0];
            autoreload <= wdata[1];
        end else if (ovf_evt && !autoreload) begin
            run        <= 1'b0;
        end
    end

    // R2: running and untouched, the counter steps by one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr && !sclr && !(&count)) |=> (count == $past(count) + ONE));
    // R2: stopped and untouched, the counter holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !sclr) |=> $stable(count));
    // R3: a counter write lands on the next edge.
    a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !sclr) |=> (count == $past(wdata)));
    // R4: auto-reload takes the load value and keeps running.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && autoreload && !sclr && !load_wr && !ctrl_wr) |=> (count == $past(load) && run));
    // R5: one-shot overflow wraps to zero and stops.
    a_r5_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !autoreload && !sclr && !ctrl_wr) |=> (count == '0 && !run));
endmodule

// File: rtl/ovf_timer_irq.sv
// Module: interrupt status and enables. Events set raw bits; writes of
// ones acknowledge them (event wins); separate set/clear enable writes
// (clear wins). irq is the OR of raw AND enable.
module ovf_timer_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclr,
    input  logic [N-1:0] evt,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic         ack_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] ack_mask, set_mask, clr_mask;

    assign ack_mask = ack_wr ? wdata : '0;
    assign set_mask = set_wr ? wdata : '0;
    assign clr_mask = clr_wr ? wdata : '0;
    assign irq      = |(raw & en);

    // Pending bits: acknowledge first, then new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr) raw <= '0;
        else                raw <= (raw & ~ack_mask) | evt;
    end

    // Enable bits: set, then clear, so clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr) en <= '0;
        else                en <= (en | set_mask) & ~clr_mask;
    end

    // R8: an event is pending on the next cycle even under acknowledge.
    a_r8_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt && !sclr) |=> ((raw & $past(evt)) == $past(evt)));
    // R7: cleared enables are off on the next cycle.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((en & $past(clr_mask)) == '0));
    // R7: set-only enables are on on the next cycle.
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_mask & ~clr_mask) && !sclr) |=>
            ((en & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));
endmodule

// File: rtl/ovf_timer.sv
// Module: top of the overflow timer. Decodes the register port, gates
// writes while a soft reset is busy and builds the read mux.
// Assumes single-cycle writes and combinational reads; unmapped reads are 0.
module ovf_timer
    import ovf_timer_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          SRST_CYCLES = 4,
    parameter logic [31:0] ID_VALUE    = 32'h4754_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic              busy, sclr, wr_ok, srst_req;
    logic [DATA_W-1:0] count, load, match_q;
    logic              run, autoreload, ovf_evt;
    logic [IRQ_N-1:0]  raw, en, evt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    assign wr_ok    = wr_en && !busy;
    assign srst_req = wr_en && hit(addr, OFF_SYNC) && wdata[1];

    ovf_timer_srst #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst_n(rst_n), .req(srst_req), .busy(busy), .sclr(sclr)
    );

    ovf_timer_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .sclr(sclr),
        .cnt_wr (wr_ok && hit(addr, OFF_COUNT)),
        .load_wr(wr_ok && hit(addr, OFF_LOAD)),
        .ctrl_wr(wr_ok && hit(addr, OFF_CTRL)),
        .wdata(wdata), .count(count), .load(load),
        .run(run), .autoreload(autoreload), .ovf_evt(ovf_evt)
    );

    // Event vector: only the overflow source is wired in this block.
    always_comb begin
        evt = '0;
        evt[IRQ_OVF_BIT] = ovf_evt;
    end

    ovf_timer_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .sclr(sclr), .evt(evt),
        .set_wr(wr_ok && hit(addr, OFF_EN_SET)),
        .clr_wr(wr_ok && hit(addr, OFF_EN_CLR)),
        .ack_wr(wr_ok && hit(addr, OFF_STATUS)),
        .wdata(wdata[IRQ_N-1:0]), .raw(raw), .en(en), .irq(irq)
    );

    // Match register: storage only.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr)                   match_q <= '0;
        else if (wr_ok && hit(addr, OFF_MATCH)) match_q <= wdata;
    end

    // Read mux over the mapped offsets.
    always_comb begin
        rdata = '0;
        if      (hit(addr, OFF_IDENT))  rdata = DATA_W'(ID_VALUE);
        else if (hit(addr, OFF_CONFIG)) rdata = DATA_W'(busy);
        else if (hit(addr, OFF_RAW))    rdata = DATA_W'(raw);
        else if (hit(addr, OFF_STATUS)) rdata = DATA_W'(raw & en);
        else if (hit(addr, OFF_EN_SET) || hit(addr, OFF_EN_CLR)) rdata = DATA_W'(en);
        else if (hit(addr, OFF_CTRL))   rdata = DATA_W'({autoreload, run});
        else if (hit(addr, OFF_COUNT))  rdata = count;
        else if (hit(addr, OFF_LOAD))   rdata = load;
        else if (hit(addr, OFF_MATCH))  rdata = match_q;
    end

    // R9: while busy, the cleared state stays zero.
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count == '0 && !run && raw == '0 && en == '0));
    // R10: a match write lands on the next edge.
    a_r10_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && hit(addr, OFF_MATCH) && !sclr) |=> (match_q == $past(wdata)));
    // R6: the interrupt line only rises with an enabled pending bit.
    a_r6_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt) || $past(|set_of_en_rise())));

    function automatic logic [IRQ_N-1:0] set_of_en_rise();
        return (wr_ok && hit(addr, OFF_EN_SET)) ? wdata[IRQ_N-1:0] : '0;
    endfunction
endmodule

// File: tb/ovf_timer_test.sv
// Bench: directed corner cases then seeded random traffic, every cycle
// compared with a model built from the requirements.
module ovf_timer_test;
    localparam int SR = 4;
    localparam logic [31:0] ID = 32'h4754_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    ovf_timer #(.SRST_CYCLES(SR), .ID_VALUE(ID)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // Model state
    logic [31:0] m_cnt, m_load, m_match;
    logic        m_run, m_ar;
    logic [2:0]  m_raw, m_en;
    int          m_busy;

    // Model update on each edge, from R2..R10.
    always @(posedge clk) begin
        logic trig, ovf, wok;
        logic [2:0] ack, st, cl;
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_match = 0; m_run = 0; m_ar = 0;
            m_raw = 0; m_en = 0; m_busy = 0;
        end else begin
            trig = wr_en && addr == 8'h54 && wdata[1] && m_busy == 0;
            if (trig || m_busy > 0) begin
                m_cnt = 0; m_load = 0; m_match = 0; m_run = 0; m_ar = 0;
                m_raw = 0; m_en = 0;
                m_busy = trig ? SR : m_busy - 1;
            end else begin
                wok = wr_en;
                ovf = m_run && !(wok && addr == 8'h3C) && m_cnt == 32'hFFFF_FFFF;
                ack = (wok && addr == 8'h28) ? wdata[2:0] : 3'b0;
                st  = (wok && addr == 8'h2C) ? wdata[2:0] : 3'b0;
                cl  = (wok && addr == 8'h30) ? wdata[2:0] : 3'b0;
                if (wok && addr == 8'h3C) m_cnt = wdata;
                else if (ovf)             m_cnt = m_ar ? m_load : 32'd0;
                else if (m_run)           m_cnt = m_cnt + 1;
                if (wok && addr == 8'h38) begin m_run = wdata[0]; m_ar = wdata[1]; end
                else if (ovf && !m_ar)    m_run = 1'b0;
                if (wok && addr == 8'h40) m_load = wdata;
                if (wok && addr == 8'h4C) m_match = wdata;
                m_raw = (m_raw & ~ack) | (ovf ? 3'b010 : 3'b000);
                m_en  = (m_en | st) & ~cl;
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return ID;
            8'h10: return {31'b0, m_busy > 0};
            8'h24: return {29'b0, m_raw};
            8'h28: return {29'b0, m_raw & m_en};
            8'h2C, 8'h30: return {29'b0, m_en};
            8'h38: return {30'b0, m_ar, m_run};
            8'h3C: return m_cnt;
            8'h40: return m_load;
            8'h4C: return m_match;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [7:0] a);
        case (a)
            8'h00: return "R1 ident";
            8'h10: return "R9 busy";
            8'h24: return "R6 raw/R8";
            8'h28: return "R6 status/R8";
            8'h2C, 8'h30: return "R7 enables";
            8'h38: return "R5 control";
            8'h3C: return "R2/R3/R4/R5 counter";
            8'h40: return "R4 load";
            8'h4C: return "R10 match";
            default: return "R1 unmapped";
        endcase
    endfunction

    // Compare read data and irq (R6) at the falling edge.
    task automatic check();
        logic [31:0] e;
        logic ei;
        e = exp_read(addr);
        ei = |(m_raw & m_en);
        vectors++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag(addr), addr, rdata, e);
        end
        vectors++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL R6 irq actual=%b expected=%b", irq, ei);
        end
    endtask

    // One bus cycle: drive at the falling edge, check one cycle later.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
        wr_en = we; addr = a; wdata = d;
        @(negedge clk);
        check();
    endtask

    task automatic rd(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0);
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] offs [11];
        logic [7:0] a;
        logic [31:0] d;
        int k;
        offs = '{8'h00, 8'h10, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h38, 8'h3C, 8'h40, 8'h4C, 8'h60};
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state across every offset, also while reset is held.
        for (int i = 0; i < 11; i++) cyc(1'b0, offs[i], 0);
        rst_n = 1'b1;
        for (int i = 0; i < 11; i++) cyc(1'b0, offs[i], 0);
        rd(8'h54, 1);
        // R2: count from zero, then stop and hold.
        cyc(1'b1, 8'h38, 32'h1);
        rd(8'h3C, 6);
        cyc(1'b1, 8'h38, 32'h0);
        rd(8'h3C, 4);
        // R3: write while running overrides the increment.
        cyc(1'b1, 8'h38, 32'h1);
        cyc(1'b1, 8'h3C, 32'h1234_5678);
        rd(8'h3C, 3);
        // R4/R6/R7: auto-reload overflow with overflow enabled.
        cyc(1'b1, 8'h40, 32'h0000_0100);
        cyc(1'b1, 8'h2C, 32'h2);
        cyc(1'b1, 8'h3C, 32'hFFFF_FFFE - 3);
        cyc(1'b1, 8'h38, 32'h3);
        rd(8'h3C, 8);
        rd(8'h28, 2);
        // R8: acknowledge, then masked pending via enable-clear.
        cyc(1'b1, 8'h28, 32'h7);
        rd(8'h24, 1);
        cyc(1'b1, 8'h30, 32'h7);
        cyc(1'b1, 8'h3C, 32'hFFFF_FFFD);
        rd(8'h24, 4);
        rd(8'h28, 1);
        cyc(1'b1, 8'h2C, 32'h7);
        rd(8'h28, 1);
        // R8: acknowledge on the overflow edge keeps the bit.
        cyc(1'b1, 8'h3C, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h28, 32'h7);
        rd(8'h24, 2);
        cyc(1'b1, 8'h28, 32'h7);
        // R5: one-shot wraps to zero and clears run.
        cyc(1'b1, 8'h38, 32'h1);
        cyc(1'b1, 8'h3C, 32'hFFFF_FFFC);
        rd(8'h3C, 6);
        rd(8'h38, 2);
        // R10: match storage.
        cyc(1'b1, 8'h4C, 32'hA5A5_0F0F);
        rd(8'h4C, 2);
        // R9: soft reset, writes during busy are dropped.
        cyc(1'b1, 8'h38, 32'h3);
        cyc(1'b1, 8'h54, 32'h2);
        cyc(1'b1, 8'h40, 32'hDEAD_BEEF);
        cyc(1'b1, 8'h38, 32'h1);
        rd(8'h10, 3);
        rd(8'h40, 2);
        rd(8'h38, 2);
        // Random phase over all offsets.
        for (int i = 0; i < 4000; i++) begin
            k = $urandom_range(0, 99);
            d = $urandom;
            if (k < 45) begin
                cyc(1'b0, offs[$urandom_range(0, 10)], 0);
            end else if (k < 55) begin
                cyc(1'b1, 8'h38, {30'b0, d[1:0]});
            end else if (k < 63) begin
                cyc(1'b1, 8'h3C, d[0] ? (32'hFFFF_FFF0 | {28'b0, d[7:4]}) : d);
            end else if (k < 68) begin
                cyc(1'b1, 8'h40, d);
            end else if (k < 76) begin
                a = d[8] ? 8'h2C : 8'h30;
                cyc(1'b1, a, {29'b0, d[2:0]});
            end else if (k < 84) begin
                cyc(1'b1, 8'h28, {29'b0, d[2:0]});
            end else if (k < 88) begin
                cyc(1'b1, 8'h4C, d);
            end else if (k < 90) begin
                cyc(1'b1, 8'h54, d);
            end else begin
                cyc(1'b1, offs[$urandom_range(0, 10)], d & 32'hFFFF_FFFD);
            end
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule